// File: doc/BRIEF.md
# Ring Node Transmit Stage with FCS Regeneration

This block sits at the output of a ring node. It takes one frame at a time from an upstream byte stream. Control tokens open and close each frame. The block drives the frame onto a 4-bit MII-style transmit interface.

The opening token says how the frame check sequence is handled. With value 3, the frame already ends in its own CRC. With value 0, the CRC was removed by an earlier stage and must be rebuilt. The block keeps this choice for the whole frame. It runs CRC-32 over every data byte it accepts. At the closing token it does one of three things:
- forward the bytes untouched,
- append a fresh CRC, or
- spoil the final byte so the next node drops the frame.

Preamble and start delimiter are generated locally. The block holds one data byte back, so the last byte can still be changed once the closing token shows the frame ended badly.

Top module: `ring_tx_stage`

## Requirements
- R1: While idle, `in_ready_o` is high. Data items and control tokens whose low nibble is neither 0 nor 3 are consumed and discarded, and `tx_en_o` stays low.
- R2: A control item whose low nibble is 3 or 0, accepted while idle, raises `tx_en_o` on the next cycle. The frame then starts with 7 bytes of 0x55 followed by one byte of 0xD5.
- R3: Each byte is sent as two nibbles on `txd_o`, bits [3:0] first. `tx_en_o` stays high without a break from the first preamble nibble to the last frame nibble, so every frame has an even nibble count.
- R4: `in_ready_o` is low for the 14 cycles after the opening token is accepted, while the 7 preamble bytes go out.
- R5: Opening token 3 with closing token 0: the data bytes, including the frame's own trailing CRC, go out unchanged and in order.
- R6: Opening token 0 with closing token 0: the data bytes are followed by the one's complement of CRC-32, sent least significant byte first. The CRC uses reflected polynomial 0xEDB88320 and starts from 0xFFFFFFFF. Data "123456789" ends in bytes 26 39 F4 CB. An empty frame ends in 00 00 00 00.
- R7: Opening token 3 with closing token 15: every bit of the last data byte is inverted.
- R8: Opening token 0 with closing token 15: every bit of the last appended CRC byte is inverted.
- R9: If no stream item is present when the next byte is due, the block sends a byte time with `tx_er_o` high. It then resumes, and the bytes sent with `tx_er_o` low are exactly the frame that would have gone out without the gap.
- R10: `tx_en_o` is low for at least one cycle between frames, and frames sent back to back each come out complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Stream item present |
| in_ready_o | output | 1 | Stream item taken on this edge when valid |
| in_ctrl_i | input | 1 | Item is a control token (value in bits [3:0]) |
| in_data_i | input | 8 | Data byte or token value |
| txd_o | output | 4 | Transmit nibble |
| tx_en_o | output | 1 | Transmit enable |
| tx_er_o | output | 1 | Transmit error, marks an underrun byte time |

## Verification
The bench checks the closing-token decision in all four opening/closing combinations:
- A design that did not store the opening token would append a CRC to a frame that already has one.
- A design without the one-byte hold could not spoil the true last byte of a frame that keeps its own CRC.

The CRC is compared against the known check value and against an empty frame. An initial value or byte order that was wrong there would show up as a different tail.

Readiness during preamble and a mid-frame source stall are also covered. A design that lost or duplicated a byte around an underrun would produce a clean-byte stream that no longer matches the frame. Frames sent back to back must each come out as a single unbroken burst.

// File: rtl/ring_tx_pkg.sv
package ring_tx_pkg;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;
  localparam int unsigned CRC_W      = 32;

  localparam logic [7:0] PRE_VAL = 8'h55;
  localparam logic [7:0] SFD_VAL = 8'hD5;

  localparam logic [3:0] TOK_HAS_FCS = 4'd3;
  localparam logic [3:0] TOK_NO_FCS  = 4'd0;
  localparam logic [3:0] TOK_END_OK  = 4'd0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_FCS,
    ST_FIN
  } tx_state_e;
endpackage

// File: rtl/ring_tx_crc.sv
module ring_tx_crc
  import ring_tx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  fcs_o
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q ^ {{(CRC_W-BYTE_W){1'b0}}, data_i};
    for (int i = 0; i < BYTE_W; i++) begin
      crc_d = crc_d[0] ? ((crc_d >> 1) ^ CRC_POLY_R) : (crc_d >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (init_i) crc_q <= CRC_SEED;
    else if (en_i)   crc_q <= crc_d;
  end

  assign fcs_o = ~crc_q;
endmodule

// File: rtl/ring_tx_ser.sv
module ring_tx_ser #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              err_i,
  output logic              need_o,
  output logic              act_o,
  output logic [NIB_W-1:0]  txd_o,
  output logic              tx_en_o,
  output logic              tx_er_o
);
  localparam int unsigned NIBS = BYTE_W / NIB_W;
  localparam int unsigned PH_W = (NIBS > 1) ? $clog2(NIBS) : 1;

  logic              act_q, er_q;
  logic [PH_W-1:0]   ph_q;
  logic [BYTE_W-1:0] sb_q;
  logic [NIB_W-1:0]  nib [NIBS];

  // slice the held byte into nibbles, lowest first
  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign nib[g] = sb_q[g*NIB_W +: NIB_W];
  end

  assign need_o = act_q && (ph_q == PH_W'(NIBS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      er_q  <= 1'b0;
      ph_q  <= '0;
      sb_q  <= '0;
    end else if (ld_i) begin
      act_q <= 1'b1;
      er_q  <= err_i;
      ph_q  <= '0;
      sb_q  <= byte_i;
    end else if (act_q) begin
      if (need_o) begin
        act_q <= 1'b0;
        er_q  <= 1'b0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  always_comb begin
    txd_o = '0;
    for (int i = 0; i < NIBS; i++) begin
      if (ph_q == PH_W'(i)) txd_o = nib[i];
    end
  end

  assign act_o   = act_q;
  assign tx_en_o = act_q;
  assign tx_er_o = act_q && er_q;
endmodule

// File: rtl/ring_tx_ctrl.sv
module ring_tx_ctrl
  import ring_tx_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned TOK_W     = 4,
  parameter int unsigned PRE_BYTES = 7,
  parameter int unsigned FCS_BYTES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  logic                        in_ctrl_i,
  input  logic [BYTE_W-1:0]           in_data_i,
  output logic                        in_ready_o,
  input  logic                        need_i,
  input  logic                        act_i,
  input  logic [FCS_BYTES*BYTE_W-1:0] fcs_i,
  output logic                        ld_o,
  output logic [BYTE_W-1:0]           ld_byte_o,
  output logic                        ld_err_o,
  output logic                        crc_init_o,
  output logic                        crc_en_o
);
  localparam int unsigned CNT_W = $clog2(PRE_BYTES + FCS_BYTES + 1);
  localparam int unsigned FB_W  = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              keep_q, bad_q, pend_v_q;
  logic [BYTE_W-1:0] pend_q;
  logic [TOK_W-1:0]  tok;
  logic              start_ok, end_bad, take;
  logic [BYTE_W-1:0] fcs_b [FCS_BYTES];
  logic [BYTE_W-1:0] fcs_sel;

  for (genvar g = 0; g < FCS_BYTES; g++) begin : g_fcs
    assign fcs_b[g] = fcs_i[g*BYTE_W +: BYTE_W];
  end

  assign tok      = in_data_i[TOK_W-1:0];
  assign start_ok = (tok == TOK_W'(TOK_HAS_FCS)) || (tok == TOK_W'(TOK_NO_FCS));
  assign end_bad  = (tok != TOK_W'(TOK_END_OK));
  assign fcs_sel  = fcs_b[cnt_q[FB_W-1:0]];

  always_comb begin
    in_ready_o = 1'b0;
    ld_o       = 1'b0;
    ld_byte_o  = '0;
    ld_err_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        in_ready_o = 1'b1;
        if (in_valid_i && in_ctrl_i && start_ok) begin
          ld_o      = 1'b1;
          ld_byte_o = PRE_VAL;
        end
      end
      ST_PRE: begin
        if (need_i) begin
          ld_o      = 1'b1;
          ld_byte_o = (cnt_q < CNT_W'(PRE_BYTES)) ? PRE_VAL : SFD_VAL;
        end
      end
      ST_DATA: begin
        // off-slot: only fill an empty hold; end token waits for the slot
        in_ready_o = need_i || (!pend_v_q && !in_ctrl_i);
        if (need_i) begin
          if (in_valid_i && pend_v_q) begin
            ld_o      = 1'b1;
            ld_byte_o = pend_q ^ ((in_ctrl_i && keep_q && end_bad) ? '1 : '0);
          end else if (in_valid_i && in_ctrl_i) begin
            ld_o      = !keep_q;
            ld_byte_o = fcs_b[0];
          end else begin
            ld_o     = 1'b1;
            ld_err_o = 1'b1;
          end
        end
      end
      ST_FCS: begin
        if (need_i) begin
          ld_o      = 1'b1;
          ld_byte_o = fcs_sel ^ ((cnt_q == CNT_W'(FCS_BYTES - 1) && bad_q) ? '1 : '0);
        end
      end
      default: ;
    endcase
  end

  assign take       = in_valid_i && in_ready_o;
  assign crc_init_o = (state_q == ST_IDLE) && take && in_ctrl_i && start_ok;
  assign crc_en_o   = (state_q == ST_DATA) && take && !in_ctrl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      keep_q   <= 1'b0;
      bad_q    <= 1'b0;
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (crc_init_o) begin
            keep_q   <= (tok == TOK_W'(TOK_HAS_FCS));
            bad_q    <= 1'b0;
            pend_v_q <= 1'b0;
            cnt_q    <= CNT_W'(1);
            state_q  <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (need_i) begin
            if (cnt_q < CNT_W'(PRE_BYTES)) cnt_q <= cnt_q + 1'b1;
            else                           state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (take && !in_ctrl_i) begin
            pend_q   <= in_data_i;
            pend_v_q <= 1'b1;
          end else if (take && in_ctrl_i) begin
            pend_v_q <= 1'b0;
            bad_q    <= end_bad;
            if (keep_q) begin
              state_q <= ST_FIN;
            end else begin
              cnt_q   <= pend_v_q ? CNT_W'(0) : CNT_W'(1);
              state_q <= ST_FCS;
            end
          end
        end
        ST_FCS: begin
          if (need_i) begin
            if (cnt_q == CNT_W'(FCS_BYTES - 1)) state_q <= ST_FIN;
            else                                cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_FIN: begin
          if (!act_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_tx_stage.sv
module ring_tx_stage
  import ring_tx_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NIB_W     = 4,
  parameter int unsigned TOK_W     = 4,
  parameter int unsigned PRE_BYTES = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_ctrl_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic [NIB_W-1:0]  txd_o,
  output logic              tx_en_o,
  output logic              tx_er_o
);
  localparam int unsigned FCS_BYTES = CRC_W / BYTE_W;

  logic              need, act, ld, ld_err, crc_init, crc_en;
  logic [BYTE_W-1:0] ld_byte;
  logic [CRC_W-1:0]  fcs;

  ring_tx_ctrl #(
    .BYTE_W   (BYTE_W),
    .TOK_W    (TOK_W),
    .PRE_BYTES(PRE_BYTES),
    .FCS_BYTES(FCS_BYTES)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(in_valid_i),
    .in_ctrl_i (in_ctrl_i),
    .in_data_i (in_data_i),
    .in_ready_o(in_ready_o),
    .need_i    (need),
    .act_i     (act),
    .fcs_i     (fcs),
    .ld_o      (ld),
    .ld_byte_o (ld_byte),
    .ld_err_o  (ld_err),
    .crc_init_o(crc_init),
    .crc_en_o  (crc_en)
  );

  ring_tx_crc #(.BYTE_W(BYTE_W)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(crc_init),
    .en_i  (crc_en),
    .data_i(in_data_i),
    .fcs_o (fcs)
  );

  ring_tx_ser #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld),
    .byte_i (ld_byte),
    .err_i  (ld_err),
    .need_o (need),
    .act_o  (act),
    .txd_o  (txd_o),
    .tx_en_o(tx_en_o),
    .tx_er_o(tx_er_o)
  );
endmodule

// File: rtl/ring_tx_chk.sv
module ring_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic       in_ctrl_i,
  input logic [7:0] in_data_i,
  input logic [3:0] txd_o,
  input logic       tx_en_o,
  input logic       tx_er_o
);
  logic par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) par_q <= 1'b0;
    else         par_q <= tx_en_o ? ~par_q : 1'b0;
  end

  AST_START_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_o && in_valid_i && in_ready_o && in_ctrl_i &&
     (in_data_i[3:0] == 4'd3 || in_data_i[3:0] == 4'd0)) |=> tx_en_o); // R2
  AST_PRE_NIB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> (txd_o == 4'h5)); // R2
  AST_PRE_NORDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> !in_ready_o); // R4
  AST_EVEN_NIB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en_o) |-> !par_q); // R3
  AST_ER_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_er_o |-> tx_en_o); // R9
  AST_IFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en_o) |=> !tx_en_o); // R10
endmodule

bind ring_tx_stage ring_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o),
  .in_ctrl_i (in_ctrl_i),
  .in_data_i (in_data_i),
  .txd_o     (txd_o),
  .tx_en_o   (tx_en_o),
  .tx_er_o   (tx_er_o)
);

// File: tb/sim_ring_tx_stage.sv
module sim_ring_tx_stage;
  typedef logic [7:0] bq_t[$];

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ctrl_i = 1'b0;
  logic [7:0] in_data_i = 8'h00;
  logic       in_ready_o;
  logic [3:0] txd_o;
  logic       tx_en_o, tx_er_o;

  always #4 clk_i = ~clk_i;

  ring_tx_stage u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_ctrl_i(in_ctrl_i), .in_data_i(in_data_i), .txd_o(txd_o),
    .tx_en_o(tx_en_o), .tx_er_o(tx_er_o)
  );

  int n_run = 0, n_fail = 0;
  logic [3:0] cap[$];
  int er_seen = 0, fr_cnt = 0;
  bit in_fr = 0;

  always @(negedge clk_i) begin
    if (tx_en_o) begin
      in_fr = 1;
      if (tx_er_o) er_seen++;
      else cap.push_back(txd_o);
    end else if (in_fr) begin
      in_fr = 0;
      fr_cnt++;
    end
  end

  function automatic logic [31:0] crc_ref(bq_t d);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (d[k]) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ d[k][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic put(logic c, logic [7:0] d);
    in_valid_i = 1'b1;
    in_ctrl_i  = c;
    in_data_i  = d;
    #1;
    while (!in_ready_o) begin
      @(negedge clk_i);
      #1;
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic wait_frame(int base);
    int t = 0;
    while (fr_cnt == base && t < 3000) begin
      @(negedge clk_i);
      t++;
    end
    @(negedge clk_i);
  endtask

  task automatic run_frame(logic [3:0] st, bq_t body, logic [3:0] en, int gap_at, int gap_len,
                           bit rdy_chk, string rq);
    bq_t exp, pl;
    int base, mism;
    cap.delete();
    er_seen = 0;
    base = fr_cnt;
    put(1'b1, {4'h0, st});
    if (rdy_chk) begin
      int hi = 0;
      repeat (14) begin
        if (in_ready_o) hi++;
        @(negedge clk_i);
      end
      chk(hi == 0, "R4", "ready high cycles in preamble", hi, 0);
    end
    foreach (body[i]) begin
      if (i == gap_at) repeat (gap_len) @(negedge clk_i);
      put(1'b0, body[i]);
    end
    put(1'b1, {4'h0, en});
    wait_frame(base);
    pl = body;
    if (st == 4'd0) begin
      logic [31:0] f;
      f = crc_ref(body);
      for (int k = 0; k < 4; k++) pl.push_back(f[k*8 +: 8]);
    end
    if (en != 4'd0 && pl.size() > 0) pl[pl.size()-1] = ~pl[pl.size()-1];
    repeat (7) exp.push_back(8'h55);
    exp.push_back(8'hD5);
    foreach (pl[i]) exp.push_back(pl[i]);
    chk(cap.size() == 2 * exp.size(), rq, "nibble count", cap.size(), 2 * exp.size());
    mism = -1;
    foreach (exp[i]) begin
      if (mism < 0 && 2 * i + 1 < cap.size() &&
          (cap[2*i] != exp[i][3:0] || cap[2*i+1] != exp[i][7:4])) mism = i;
    end
    chk(mism < 0, rq, "first mismatching byte index", mism, -1);
    chk(fr_cnt == base + 1, "R3", "tx_en bursts per frame", fr_cnt - base, 1);
  endtask

  task automatic t_reset();
    chk(!tx_en_o && !tx_er_o, "R1", "tx_en/tx_er in reset", {tx_en_o, tx_er_o}, 0);
    chk(in_ready_o, "R1", "ready while idle", in_ready_o, 1);
  endtask

  task automatic t_idle_ignore();
    int base = fr_cnt;
    cap.delete();
    put(1'b0, 8'hAA);
    put(1'b1, 8'h07);
    put(1'b1, 8'h0F);
    put(1'b0, 8'h03);
    repeat (20) @(negedge clk_i);
    chk(fr_cnt == base && !in_fr && cap.size() == 0, "R1", "activity after ignored items",
        cap.size(), 0);
  endtask

  task automatic t_keep_ok();
    bq_t b = '{8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65, 8'hA7, 8'hB8, 8'hC9, 8'hDA};
    int bad = 0;
    run_frame(4'd3, b, 4'd0, -1, 0, 1'b0, "R5");
    for (int i = 0; i < 16 && i < cap.size(); i++) begin
      if (cap[i] != ((i == 15) ? 4'hD : 4'h5)) bad++;
    end
    chk(bad == 0 && cap.size() >= 16, "R2", "preamble nibble errors", bad, 0);
  endtask

  task automatic t_crc_known();
    bq_t b = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    logic [31:0] tail = '0;
    run_frame(4'd0, b, 4'd0, -1, 0, 1'b0, "R6");
    if (cap.size() >= 8)
      for (int k = 0; k < 8; k++) tail[k*4 +: 4] = cap[cap.size() - 8 + k];
    chk(tail == 32'hCBF43926, "R6", "appended check value", tail, 32'hCBF43926);
  endtask

  task automatic t_crc_empty();
    bq_t b = {};
    run_frame(4'd0, b, 4'd0, -1, 0, 1'b0, "R6");
  endtask

  task automatic t_keep_bad();
    bq_t b = '{8'h5A, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h3C};
    run_frame(4'd3, b, 4'd15, -1, 0, 1'b0, "R7");
  endtask

  task automatic t_crc_bad();
    bq_t b = '{8'hFE, 8'h00, 8'h7F, 8'h80, 8'h11};
    run_frame(4'd0, b, 4'd15, -1, 0, 1'b0, "R8");
  endtask

  task automatic t_ready_pre();
    bq_t b = '{8'h99, 8'h88, 8'h77};
    run_frame(4'd0, b, 4'd0, -1, 0, 1'b1, "R4");
  endtask

  task automatic t_underrun();
    bq_t b = '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB};
    run_frame(4'd0, b, 4'd0, 3, 7, 1'b0, "R9");
    chk(er_seen > 0, "R9", "error nibbles during stall", er_seen, 1);
  endtask

  task automatic t_back2back();
    bq_t b1 = '{8'hC0, 8'hC1, 8'hC2};
    bq_t b2 = '{8'hD0, 8'hD1};
    int base = fr_cnt;
    run_frame(4'd0, b1, 4'd0, -1, 0, 1'b0, "R10");
    run_frame(4'd3, b2, 4'd0, -1, 0, 1'b0, "R10");
    chk(fr_cnt == base + 2, "R10", "frames seen", fr_cnt - base, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_idle_ignore();
    t_keep_ok();
    t_crc_known();
    t_crc_empty();
    t_keep_bad();
    t_crc_bad();
    t_ready_pre();
    t_underrun();
    t_back2back();
    repeat (5) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule